// File: doc/BRIEF.md
# Glitch-free redundant clock switch

This block picks one of two clock sources and passes it to a single clock output. An asynchronous select moves the output from the running source to the other one. The change never produces a high or low phase shorter than half a source period. Each source has its own gating leg. A leg brings the select into its own clock domain and opens or closes its gate only while its clock is low. A leg opens its gate only after it has seen that the other gate is closed.

A plain glitch-free mux hangs when the source being left has stopped, because nothing is left to clock its gate shut. Here the incoming leg counts its own rising edges while it waits. If the other side has not released after a set number of edges, the incoming leg closes the old gate asynchronously. The output first holds the level at which the old clock stopped, then goes low, then follows the new clock. A bypass input turns the block into a plain combinational 2:1 mux. An active-low reset closes both gates at power-up.

Top module: `gclk_switch`

## Requirements
- R1: While `rst_n` is low and `bypass` is low, `clk_o` is low. After reset, an output with both gates closed is low.
- R2: Outside bypass, the two gates are never open at the same time. With both sources running, within a 1.5:1 frequency ratio, no high or low phase of `clk_o` is shorter than half the shorter source period, across every switchover.
- R3: With both sources running, `clk_o` equals the newly selected source no later than 17 of that source's periods after `sel` changes. `sel`=1 selects `src1_clk` and `sel`=0 selects `src0_clk`.
- R4: If the source being left is stopped high, `clk_o` stays high for at least two periods of the new source after `sel` changes. It then goes low and follows the new source within 17 of its periods. A leg closes the other gate by force only while it wants its own gate open and that gate is still closed.
- R5: If the source being left is stopped low, `clk_o` stays low for at least two periods of the new source after `sel` changes. It then follows the new source within 17 of its periods.
- R6: With `bypass` high, `clk_o` is `src1_clk` when `sel`=1 and `src0_clk` when `sel`=0, combinationally and with no delay.
- R7: The switch behaves the same in both directions. Either source may serve as the primary.
- R8: After `rst_n` is released, `clk_o` follows the source chosen by `sel` within 17 of that source's periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src0_clk | input | 1 | Clock source chosen when `sel` is 0 |
| src1_clk | input | 1 | Clock source chosen when `sel` is 1 |
| sel | input | 1 | Asynchronous source select |
| bypass | input | 1 | High: plain combinational mux, with no protection |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| clk_o | output | 1 | Switched clock output |

## Verification
The bench builds the block with two synchronizer stages and a stall limit of eight edges. It drives the sources at 16 ns and 20 ns, a 1.25:1 ratio. At these values the stall detector never fires while both clocks run, and the worst-case forced handover still lands inside the 17-period bound. Every phase of the output is timed against the 8 ns floor. Each direction is run with the old source running, stopped high and stopped low. The bypass mux is swept over all eight input combinations.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

  // The stall counter reaches the limit on the edge where it holds limit-1.
  function automatic logic stall_hit(input int cnt, input int limit);
    return cnt == (limit - 1);
  endfunction

  // Worst-case new-clock periods from a select change to a following output:
  // select sync, stall count, release sync back, and one half-cycle to open.
  function automatic int settle_bound(input int stages, input int limit);
    return stages + limit + stages + 1;
  endfunction

endpackage

// File: rtl/gclk_sync.sv
module gclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) shreg <= '0;
    else       shreg <= {shreg[STAGES-2:0], d_i};
  end

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/gclk_leg.sv
module gclk_leg
  import gclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic want_req_i,
  input  logic peer_en_i,
  input  logic peer_kill_i,
  output logic en_o,
  output logic want_o,
  output logic kill_o
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);

  logic             clr_want;
  logic             rst_clr;
  logic             want_s;
  logic             peer_seen;
  logic             en_q;
  logic             kill_q;
  logic             waiting;
  logic [CNT_W-1:0] cnt;

  // A forced release from the other leg also empties this leg's request
  // chain, so a stopped clock that restarts cannot open with a stale request.
  assign clr_want = ~rst_n | peer_kill_i;
  assign rst_clr  = ~rst_n;

  gclk_sync #(.STAGES(SYNC_STAGES)) u_want_sync (
    .clk_i (clk_i),
    .clr_i (clr_want),
    .d_i   (want_req_i),
    .q_o   (want_s)
  );

  gclk_sync #(.STAGES(SYNC_STAGES)) u_peer_sync (
    .clk_i (clk_i),
    .clr_i (rst_clr),
    .d_i   (peer_en_i),
    .q_o   (peer_seen)
  );

  // The gate changes only while this clock is low.
  always_ff @(negedge clk_i or posedge clr_want) begin
    if (clr_want) en_q <= 1'b0;
    else          en_q <= want_s & (en_q | ~peer_seen);
  end

  assign waiting = want_s & ~en_q & peer_seen;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!waiting || kill_q) cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= want_s & ~en_q &
                          (kill_q | (waiting & stall_hit(int'(cnt), STALL_LIMIT)));
  end

  assign en_o   = en_q;
  assign want_o = want_s;
  assign kill_o = kill_q;
endmodule

// File: rtl/gclk_switch.sv
module gclk_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_LIMIT = 8
) (
  input  logic src0_clk,
  input  logic src1_clk,
  input  logic sel,
  input  logic bypass,
  input  logic rst_n,
  output logic clk_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] want_req;
  logic [NSRC-1:0] gate_en;
  logic [NSRC-1:0] want;
  logic [NSRC-1:0] kill;
  logic            gated;

  assign src_clk  = {src1_clk, src0_clk};
  assign want_req = {sel, ~sel};

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_leg
    gclk_leg #(
      .SYNC_STAGES (SYNC_STAGES),
      .STALL_LIMIT (STALL_LIMIT)
    ) u_leg (
      .clk_i       (src_clk[gi]),
      .rst_n       (rst_n),
      .want_req_i  (want_req[gi]),
      .peer_en_i   (gate_en[NSRC-1-gi]),
      .peer_kill_i (kill[NSRC-1-gi]),
      .en_o        (gate_en[gi]),
      .want_o      (want[gi]),
      .kill_o      (kill[gi])
    );
  end

  assign gated = |(src_clk & gate_en);
  assign clk_o = bypass ? (sel ? src1_clk : src0_clk) : gated;
endmodule

// File: rtl/gclk_switch_chk.sv
module gclk_switch_chk (
  input logic       src0_clk,
  input logic       src1_clk,
  input logic       rst_n,
  input logic       bypass,
  input logic       clk_o,
  input logic [1:0] gate_en,
  input logic [1:0] want,
  input logic [1:0] kill
);
  p_excl_a_r2: assert property (@(posedge src0_clk) disable iff (!rst_n)
    !(gate_en[0] && gate_en[1]));

  p_excl_b_r2: assert property (@(posedge src1_clk) disable iff (!rst_n)
    !(gate_en[0] && gate_en[1]));

  p_handoff_r2: assert property (@(posedge src1_clk) disable iff (!rst_n)
    $rose(gate_en[1]) |-> !gate_en[0]);

  p_kill_wait_a_r4: assert property (@(posedge src0_clk) disable iff (!rst_n)
    $rose(kill[0]) |-> (want[0] && !gate_en[0]));

  p_kill_wait_b_r5: assert property (@(posedge src1_clk) disable iff (!rst_n)
    $rose(kill[1]) |-> (want[1] && !gate_en[1]));

  p_idle_low_r1: assert property (@(posedge src0_clk) disable iff (!rst_n)
    (!bypass && gate_en == 2'b00) |-> !clk_o);
endmodule

bind gclk_switch gclk_switch_chk u_chk (
  .src0_clk (src0_clk),
  .src1_clk (src1_clk),
  .rst_n    (rst_n),
  .bypass   (bypass),
  .clk_o    (clk_o),
  .gate_en  (gate_en),
  .want     (want),
  .kill     (kill)
);

// File: tb/gclk_switch_tb.sv
`timescale 1ns/1ps
module gclk_switch_tb;
  localparam int  SETTLE = 17;
  localparam int  P0 = 16;
  localparam int  P1 = 20;
  localparam real MIN_PHASE = 7.9;

  logic tclk = 1'b0;
  logic src0_clk = 1'b0;
  logic src1_clk = 1'b0;
  logic run0 = 1'b1;
  logic run1 = 1'b1;
  logic sel = 1'b1;
  logic bypass = 1'b0;
  logic rst_n = 1'b0;
  logic clk_o;

  int  tests = 0;
  int  fails = 0;
  bit  mon_on = 1'b0;
  bit  have_last = 1'b0;
  real last_t = 0.0;

  gclk_switch #(.SYNC_STAGES(2), .STALL_LIMIT(8)) u_dut (
    .src0_clk (src0_clk),
    .src1_clk (src1_clk),
    .sel      (sel),
    .bypass   (bypass),
    .rst_n    (rst_n),
    .clk_o    (clk_o)
  );

  always #2 tclk = ~tclk;
  always begin #(P0/2); if (run0) src0_clk = ~src0_clk; end
  always begin #(P1/2); if (run1) src1_clk = ~src1_clk; end

  // Phase-width monitor for R2: every output phase lasts at least half of
  // the shorter source period.
  always @(clk_o) begin
    if (mon_on) begin
      if (have_last) begin
        tests++;
        if ($realtime - last_t < MIN_PHASE) begin
          fails++;
          $display("FAIL R2 phase width %0.3f ns, expected >= 8 ns", $realtime - last_t);
        end
      end
      last_t    = $realtime;
      have_last = 1'b1;
    end
  end

  task automatic set_mon(input bit on);
    mon_on    = on;
    have_last = 1'b0;
  endtask

  task automatic step();
    @(posedge tclk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s clk_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic follow(input bit which, input string req);
    for (int i = 0; i < 24; i++) begin
      step();
      chk(clk_o === (which ? src1_clk : src0_clk), req, clk_o,
          which ? src1_clk : src0_clk);
    end
  endtask

  task automatic stop_clk(input bit which, input logic lvl);
    if (which) begin wait (src1_clk == lvl); run1 = 1'b0; end
    else       begin wait (src0_clk == lvl); run0 = 1'b0; end
    step();
  endtask

  // Switch to new_sel. If stuck is set, the old source is stopped at lvl.
  task automatic do_switch(input bit new_sel, input bit stuck, input logic lvl,
                           input string req);
    int per;
    int hold;
    per  = new_sel ? P1 : P0;
    hold = 0;
    if (stuck) stop_clk(!new_sel, lvl);
    sel = new_sel;
    if (stuck) begin
      hold = 2 * per / 4;
      for (int i = 0; i < hold; i++) begin
        step();
        chk(clk_o === lvl, req, clk_o, lvl);
      end
    end
    repeat (SETTLE * per / 4 - hold) step();
    follow(new_sel, req);
    run0 = 1'b1;
    run1 = 1'b1;
    step();
  endtask

  initial begin : wd
    repeat (100000) @(posedge tclk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset holds the output low while both sources run
    for (int i = 0; i < 10; i++) begin
      step();
      chk(clk_o === 1'b0, "R1 reset", clk_o, 1'b0);
    end
    rst_n = 1'b1;
    // R8: power-up with sel=1
    repeat (SETTLE * P1 / 4) step();
    follow(1'b1, "R8 power-up sel=1");
    set_mon(1'b1);

    // R3, R7: both running, each direction
    do_switch(1'b0, 1'b0, 1'b0, "R3 run 1->0");
    do_switch(1'b1, 1'b0, 1'b0, "R3 R7 run 0->1");
    // R4: old source stopped high, each direction
    do_switch(1'b0, 1'b1, 1'b1, "R4 stuck-high 1->0");
    do_switch(1'b1, 1'b1, 1'b1, "R4 R7 stuck-high 0->1");
    // R5: old source stopped low, each direction
    do_switch(1'b0, 1'b1, 1'b0, "R5 stuck-low 1->0");
    do_switch(1'b1, 1'b1, 1'b0, "R5 R7 stuck-low 0->1");

    // R1 again mid-run, then R8 power-up with sel=0
    set_mon(1'b0);
    rst_n = 1'b0;
    sel   = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(clk_o === 1'b0, "R1 mid-run reset", clk_o, 1'b0);
    end
    rst_n = 1'b1;
    repeat (SETTLE * P0 / 4) step();
    follow(1'b0, "R8 power-up sel=0");

    // R6: bypass, all level combinations of src0, src1, sel
    run0   = 1'b0;
    run1   = 1'b0;
    bypass = 1'b1;
    step();
    for (int v = 0; v < 8; v++) begin
      src0_clk = v[0];
      src1_clk = v[1];
      sel      = v[2];
      #1;
      chk(clk_o === (v[2] ? v[1] : v[0]), "R6 bypass", clk_o, v[2] ? v[1] : v[0]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule